// File: doc/BRIEF.md
# Synchronous Rectifier Deadtime PWM Generator

This block is a counter-based digital pulse-width modulator for a synchronous buck power stage. In every fixed switching period it produces one enable for the control (high-side) switch and one for the synchronous rectifier (low-side) switch. The period is a fixed number of counter ticks, and one tick is the smallest timing step of the hardware.

A controller supplies four values: the commanded control on-time, a gap between the control switch turning off and the rectifier turning on, a gap between the rectifier turning off and the end of the period, and a flag that allows the rectifier to be used. The second gap can grow to cover most of the period. This lets the rectifier open just as the inductor current reaches zero in discontinuous conduction. A command below a minimum on-time produces no pulse at all, so at light load the converter skips whole periods. Clearing the rectifier flag keeps the rectifier switch off. All four inputs are sampled once, at the clock edge that begins a period, and they hold for that whole period. A strobe marks the first tick of each period.

Top module: `sr_deadtime_pwm`

## Requirements
- R1: A period lasts PERIOD ticks. `periodStart` is high during tick 0 of every period and low on every other tick.
- R2: The inputs are sampled at the rising clock edge that begins tick 0. Input changes made after that edge have no effect until the next period.
- R3: When `onCmd` >= MIN_ON, `gateHigh` is high on ticks 0 to min(`onCmd`, PERIOD)-1 and low otherwise. A command above PERIOD saturates to the full period.
- R4: When `onCmd` < MIN_ON (default 2), `gateHigh` and `gateLow` both stay low for the whole period.
- R5: `gateLow` turns on no earlier than tick min(`onCmd`, PERIOD) + `offGap`.
- R6: `gateLow` is high up to and including tick PERIOD-`onGap`-1 and low from tick PERIOD-`onGap` on. An `onGap` >= PERIOD gives no rectifier pulse.
- R7: When the start tick of R5 is not below the end tick of R6, `gateLow` stays low for the whole period.
- R8: When `srEnable` is 0 at the sampling edge, `gateLow` stays low for the whole period.
- R9: `gateHigh` and `gateLow` are never high in the same tick.
- R10: While `rstN` is low, all outputs are low. The first period starts at the first rising edge after `rstN` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| onCmd | input | IN_W | Commanded control on-time in ticks |
| offGap | input | IN_W | Ticks from control off to rectifier on |
| onGap | input | IN_W | Ticks from rectifier off to period end |
| srEnable | input | 1 | Allows the rectifier to be switched |
| gateHigh | output | 1 | Control switch enable |
| gateLow | output | 1 | Synchronous rectifier enable |
| periodStart | output | 1 | High during tick 0 of each period |

## Verification
The hardest case to reach from the ports is the boundary where the rectifier window closes. The window can vanish for three separate reasons: the two gaps overlap, the on-command saturates past the period, or the turn-on gap reaches or passes the period. Each of these must give a silent rectifier without disturbing the control pulse. The stimulus sweeps every on-command from zero to beyond the period against chosen gap values on both sides of these boundaries, with the rectifier flag both ways. Each new setting is applied in tick 0 of the period that is still running, so every period also tests that a mid-period change is ignored.

// File: rtl/sr_deadtime_pwm_pkg.sv
package sr_deadtime_pwm_pkg;

  // Strobes passed from the period sequencer to the gate datapath.
  typedef struct packed {
    logic loadParams;  // edge at the end of this tick begins a new period
    logic firstTick;   // current tick is tick 0
  } pwmStrobes_t;

endpackage

// File: rtl/sr_deadtime_pwm_ctrl.sv
module sr_deadtime_pwm_ctrl
  import sr_deadtime_pwm_pkg::*;
#(
  parameter int PERIOD = 64,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [CNT_W-1:0] tickCount,
  output pwmStrobes_t      strobes
);

  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] countQ;
  logic             firstQ;
  logic             atLast;

  assign atLast = (countQ == LAST_TICK);

  // Reset parks the counter on the last tick, so the first edge after
  // reset loads the inputs and enters tick 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= LAST_TICK;
      firstQ <= 1'b0;
    end else begin
      countQ <= atLast ? '0 : countQ + 1'b1;
      firstQ <= atLast;
    end
  end

  assign tickCount          = countQ;
  assign strobes.loadParams = atLast;
  assign strobes.firstTick  = firstQ;

endmodule

// File: rtl/sr_deadtime_pwm_dp.sv
module sr_deadtime_pwm_dp
  import sr_deadtime_pwm_pkg::*;
#(
  parameter int PERIOD = 64,
  parameter int MIN_ON = 2,
  localparam int CNT_W = $clog2(PERIOD),
  localparam int IN_W  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobes_t      strobes,
  input  logic [CNT_W-1:0] tickCount,
  input  logic [IN_W-1:0]  onCmd,
  input  logic [IN_W-1:0]  offGap,
  input  logic [IN_W-1:0]  onGap,
  input  logic             srEnable,
  output logic             gateHigh,
  output logic             gateLow
);

  localparam int EW = IN_W + 1;
  localparam logic [IN_W-1:0] PER_V = IN_W'(PERIOD);
  localparam logic [IN_W-1:0] MIN_V = IN_W'(MIN_ON);

  logic            pulseOk;
  logic [IN_W-1:0] effOn;
  logic [EW-1:0]   srStartW;
  logic [EW-1:0]   srEndW;
  logic            srEndOk;
  logic            srWindowOk;

  logic [IN_W-1:0] hiEndQ;
  logic [IN_W-1:0] srStartQ;
  logic [IN_W-1:0] srEndQ;
  logic            srValidQ;
  logic [IN_W-1:0] tickExt;

  // Window edges for the coming period, computed once at the load strobe.
  always_comb begin
    pulseOk    = (onCmd >= MIN_V);
    effOn      = (onCmd > PER_V) ? PER_V : onCmd;
    srStartW   = {1'b0, effOn} + {1'b0, offGap};
    srEndOk    = (onGap < PER_V);
    srEndW     = srEndOk ? ({1'b0, PER_V} - {1'b0, onGap}) : '0;
    srWindowOk = srEnable && pulseOk && srEndOk && (srStartW < srEndW);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiEndQ   <= '0;
      srStartQ <= '0;
      srEndQ   <= '0;
      srValidQ <= 1'b0;
    end else if (strobes.loadParams) begin
      hiEndQ   <= pulseOk ? effOn : '0;
      srValidQ <= srWindowOk;
      srStartQ <= srWindowOk ? srStartW[IN_W-1:0] : '0;
      srEndQ   <= srWindowOk ? srEndW[IN_W-1:0] : '0;
    end
  end

  assign tickExt  = {1'b0, tickCount};
  assign gateHigh = (tickExt < hiEndQ);
  assign gateLow  = srValidQ && (tickExt >= srStartQ) && (tickExt < srEndQ);

endmodule

// File: rtl/sr_deadtime_pwm.sv
module sr_deadtime_pwm
  import sr_deadtime_pwm_pkg::*;
#(
  parameter int PERIOD = 64,
  parameter int MIN_ON = 2,
  localparam int IN_W = $clog2(PERIOD) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [IN_W-1:0] onCmd,
  input  logic [IN_W-1:0] offGap,
  input  logic [IN_W-1:0] onGap,
  input  logic            srEnable,
  output logic            gateHigh,
  output logic            gateLow,
  output logic            periodStart
);

  localparam int CNT_W = $clog2(PERIOD);

  logic [CNT_W-1:0] tickCount;
  pwmStrobes_t      strobes;

  sr_deadtime_pwm_ctrl #(.PERIOD(PERIOD)) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .tickCount(tickCount),
    .strobes  (strobes)
  );

  sr_deadtime_pwm_dp #(.PERIOD(PERIOD), .MIN_ON(MIN_ON)) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .tickCount(tickCount),
    .onCmd    (onCmd),
    .offGap   (offGap),
    .onGap    (onGap),
    .srEnable (srEnable),
    .gateHigh (gateHigh),
    .gateLow  (gateLow)
  );

  assign periodStart = strobes.firstTick;

endmodule

// File: rtl/sr_deadtime_pwm_chk.sv
module sr_deadtime_pwm_chk #(
  parameter int PERIOD = 64,
  parameter int MIN_ON = 2,
  localparam int IN_W = $clog2(PERIOD) + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic [IN_W-1:0] onCmd,
  input logic [IN_W-1:0] offGap,
  input logic [IN_W-1:0] onGap,
  input logic            srEnable,
  input logic            gateHigh,
  input logic            gateLow,
  input logic            periodStart
);

  localparam logic [IN_W-1:0] MIN_V = IN_W'(MIN_ON);

  // R9: the two switches never conduct together
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHigh && gateLow));

  // R1: the strobe never lasts two ticks in a row
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> !periodStart);

  // R4: a command below the floor gives no pulse in tick 0
  a_r4_skip: assert property (@(posedge clk) disable iff (!rstN)
    (periodStart && ($past(onCmd) < MIN_V)) |-> (!gateHigh && !gateLow));

  // R3: an accepted command drives the control switch in tick 0
  a_r3_pulse_start: assert property (@(posedge clk) disable iff (!rstN)
    (periodStart && ($past(onCmd) >= MIN_V)) |-> gateHigh);

  // R8: a cleared rectifier flag keeps the rectifier off in tick 0
  a_r8_sr_off: assert property (@(posedge clk) disable iff (!rstN)
    (periodStart && !$past(srEnable)) |-> !gateLow);

  // R10: outputs are quiet while reset is held
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!gateHigh && !gateLow && !periodStart));

endmodule

bind sr_deadtime_pwm sr_deadtime_pwm_chk #(.PERIOD(PERIOD), .MIN_ON(MIN_ON)) chkInst (
  .clk        (clk),
  .rstN       (rstN),
  .onCmd      (onCmd),
  .offGap     (offGap),
  .onGap      (onGap),
  .srEnable   (srEnable),
  .gateHigh   (gateHigh),
  .gateLow    (gateLow),
  .periodStart(periodStart)
);

// File: tb/sr_deadtime_pwm_test.sv
module sr_deadtime_pwm_test;

  localparam int P    = 16;
  localparam int MINO = 2;
  localparam int IW   = $clog2(P) + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [IW-1:0] onCmd = '0;
  logic [IW-1:0] offGap = '0;
  logic [IW-1:0] onGap = '0;
  logic          srEnable = 1'b0;
  logic          gateHigh, gateLow, periodStart;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sr_deadtime_pwm #(.PERIOD(P), .MIN_ON(MINO)) uut (
    .clk(clk), .rstN(rstN), .onCmd(onCmd), .offGap(offGap), .onGap(onGap),
    .srEnable(srEnable), .gateHigh(gateHigh), .gateLow(gateLow),
    .periodStart(periodStart)
  );

  task automatic check(string tag, int k, logic act, logic exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s tick %0d: got %0b expected %0b", tag, k, act, exp);
    end
  endtask

  task automatic drive(int on, int dOff, int dOn, bit en);
    onCmd = IW'(on); offGap = IW'(dOff); onGap = IW'(dOn); srEnable = en;
  endtask

  // Checks one full period (caller is at the negedge of tick 0).
  task automatic checkPeriod(int on, int dOff, int dOn, bit en);
    bit ok     = (on >= MINO);
    int effOn  = (on > P) ? P : on;
    int sStart = effOn + dOff;
    int sEnd   = P - dOn;
    bit win    = en && ok && (sStart < sEnd);
    for (int k = 0; k < P; k++) begin
      logic eh = ok && (k < effOn);
      logic el = win && (k >= sStart) && (k < sEnd);
      string hiTag, loTag;
      hiTag = !ok ? "R4" : (k == 0 ? "R2/R3" : "R3");
      if (!en)            loTag = "R8";
      else if (!ok)       loTag = "R4";
      else if (!win)      loTag = "R7";
      else if (k < sStart) loTag = "R5";
      else                loTag = "R6";
      check(hiTag, k, gateHigh, eh);
      check(loTag, k, gateLow, el);
      check("R1", k, periodStart, logic'(k == 0));
      check("R9", k, logic'(gateHigh && gateLow), 1'b0);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin : stimulus
    int curOn, curOff, curDon;
    bit curEn;
    int offSet[8] = '{0, 1, 2, 3, 5, 8, 15, 20};
    int donSet[8] = '{0, 1, 2, 4, 7, 12, 16, 31};

    curOn = 5; curOff = 2; curDon = 3; curEn = 1'b1;
    drive(curOn, curOff, curDon, curEn);
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", 0, gateHigh, 1'b0);
    check("R10", 0, gateLow, 1'b0);
    check("R10", 0, periodStart, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", 0, periodStart, 1'b1);

    for (int e = 0; e < 2; e++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          for (int on = 0; on <= P + 2; on++) begin
            // New values driven during tick 0 must wait for the next period (R2).
            drive(on, offSet[a], donSet[b], bit'(e));
            checkPeriod(curOn, curOff, curDon, curEn);
            curOn = on; curOff = offSet[a]; curDon = donSet[b]; curEn = bit'(e);
          end

    drive(0, 0, 0, 1'b0);
    checkPeriod(curOn, curOff, curDon, curEn);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule